// File: doc/BRIEF.md
# CAN Mailbox Transmit Status Register Bank

This block holds the transmit-side status of a set of CAN message mailboxes (32 by default) and makes it visible to a CPU. For each mailbox it keeps four bits: a direction setting (transmit or receive), a pending-transmit flag, a cancel-request flag and a transmit-acknowledge flag. A simple register bus gives the CPU 16-bit access to one half of each of the four status vectors per address. Reads are combinational from the address; a write is applied on the clock edge while the write strobe is high.

The message engine reports two kinds of per-mailbox pulses: a successful transmission and a completed abort. A success sets the mailbox's acknowledge flag. Either pulse retires the mailbox by clearing its pending and cancel flags. The pending and cancel vectors go straight out to the transmit scheduler. The CPU can raise a pending flag only for a transmit mailbox. It can raise a cancel flag only for a mailbox that is already pending. It clears acknowledge flags by writing ones. Mailbox 0 is fixed as a receive mailbox.

Top module: `can_txstat_regs`

## Requirements
- R1: After reset every pending, cancel, acknowledge and direction bit is 0, so every register reads 0x0000 and both output vectors are 0.
- R2: Address bits [2:1] select the register: 0 pending, 1 cancel, 2 acknowledge, 3 direction. Address bit 0 selects the half: 0 covers mailboxes 15..0 and 1 covers mailboxes 31..16. Data bit n of half h belongs to mailbox 16*h+n. bus_rdata shows the addressed half in the same cycle.
- R3: A direction write stores the data bits, with 1 meaning transmit and 0 meaning receive. The direction bit of mailbox 0 always reads 0, whatever is written.
- R4: Writing 1 to a pending bit sets it only if that mailbox's stored direction is 1. Writing 0 has no effect. A mailbox that stays in receive direction, mailbox 0 included, never becomes pending.
- R5: Writing 1 to a cancel bit sets it only if, before the edge, that mailbox is both pending and set to transmit. Otherwise the write is ignored. Writing 0 never clears a cancel bit.
- R6: An abort-complete pulse for a mailbox clears its cancel and pending bits at that edge. It does not set the acknowledge bit, and it overrides a pending write of 1 in the same cycle.
- R7: A transmit-success pulse for a mailbox sets its acknowledge bit and clears its pending and cancel bits at that edge.
- R8: Writing 1 to an acknowledge bit clears it. Writing 0 leaves it unchanged. This holds for all 16 bits of both halves.
- R9: When a transmit-success pulse and a CPU write of 1 reach the same acknowledge bit in the same cycle, the bit ends up set.
- R10: Bit 0 of the low cancel register (mailbox 0) always reads 0.
- R11: pend_vec and cancel_vec equal the pending and cancel registers bit for bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed half-register |
| bus_addr | input | 3 | Register and half select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed half-register |
| tx_done | input | 32 | Per-mailbox transmit-success pulses |
| abort_done | input | 32 | Per-mailbox abort-complete pulses |
| pend_vec | output | 32 | Pending-transmit flags to the scheduler |
| cancel_vec | output | 32 | Cancel-request flags to the scheduler |

## Verification
The acknowledge bit can be set by a transmit success and cleared by a CPU write of 1 in the same cycle. The pending bit can likewise be raised by a write and retired by a completion pulse on the same edge. The bench drives each collision on purpose, with the bus write and the engine pulse placed in one cycle, and then reads the register back. It expects the acknowledge to stay set and the pending to end up clear. A long pseudo-random run then mixes writes to all eight addresses with sparse engine pulses, so that more such collisions occur, and compares every register and both vectors each cycle against an arithmetic model kept in the bench.

// File: rtl/can_txstat_pkg.sv
package can_txstat_pkg;
  typedef enum logic [1:0] {
    REG_PEND   = 2'd0,
    REG_CANCEL = 2'd1,
    REG_ACK    = 2'd2,
    REG_DIR    = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/can_txstat_wdec.sv
module can_txstat_wdec
  import can_txstat_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int WORD_W = 16,
  localparam int HALVES = NUM_MB / WORD_W,
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int ADDR_W = HALF_W + 2
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [NUM_MB-1:0] pend_w1,
  output logic [NUM_MB-1:0] cancel_w1,
  output logic [NUM_MB-1:0] ack_w1,
  output logic [NUM_MB-1:0] dir_we,
  output logic [NUM_MB-1:0] dir_val
);
  function automatic logic [NUM_MB-1:0] spread(input logic [HALF_W-1:0] h,
                                               input logic [WORD_W-1:0] d);
    logic [NUM_MB-1:0] v;
    v = '0;
    v[int'(h)*WORD_W +: WORD_W] = d;
    return v;
  endfunction

  reg_kind_e         kind;
  logic [HALF_W-1:0] half;
  logic [NUM_MB-1:0] data_mask;
  logic [NUM_MB-1:0] lane_mask;

  assign kind      = reg_kind_e'(addr[ADDR_W-1 -: 2]);
  assign half      = addr[HALF_W-1:0];
  assign data_mask = spread(half, wdata);
  assign lane_mask = spread(half, {WORD_W{1'b1}});

  always_comb begin
    pend_w1   = '0;
    cancel_w1 = '0;
    ack_w1    = '0;
    dir_we    = '0;
    if (wr) begin
      case (kind)
        REG_PEND:   pend_w1   = data_mask;
        REG_CANCEL: cancel_w1 = data_mask;
        REG_ACK:    ack_w1    = data_mask;
        default:    dir_we    = lane_mask;
      endcase
    end
  end

  assign dir_val = {HALVES{wdata}};
endmodule

// File: rtl/can_txstat_rmux.sv
module can_txstat_rmux
  import can_txstat_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int WORD_W = 16,
  localparam int HALVES = NUM_MB / WORD_W,
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int ADDR_W = HALF_W + 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_MB-1:0] pend,
  input  logic [NUM_MB-1:0] cancel,
  input  logic [NUM_MB-1:0] ack,
  input  logic [NUM_MB-1:0] dir,
  output logic [WORD_W-1:0] rdata
);
  function automatic logic [WORD_W-1:0] pick_half(input logic [NUM_MB-1:0] v,
                                                  input logic [HALF_W-1:0] h);
    return v[int'(h)*WORD_W +: WORD_W];
  endfunction

  reg_kind_e         kind;
  logic [NUM_MB-1:0] chosen;

  assign kind = reg_kind_e'(addr[ADDR_W-1 -: 2]);

  always_comb begin
    case (kind)
      REG_PEND:   chosen = pend;
      REG_CANCEL: chosen = cancel;
      REG_ACK:    chosen = ack;
      default:    chosen = dir;
    endcase
  end

  assign rdata = pick_half(chosen, addr[HALF_W-1:0]);
endmodule

// File: rtl/can_txstat_mbox.sv
module can_txstat_mbox #(
  parameter bit RX_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_w1,
  input  logic cancel_w1,
  input  logic ack_w1,
  input  logic dir_we,
  input  logic dir_val,
  input  logic tx_done,
  input  logic abort_done,
  output logic pend_q,
  output logic cancel_q,
  output logic ack_q,
  output logic dir_q
);
  // named events for checking
  logic retire;
  logic pend_set_ok;
  logic cancel_set_ok;
  logic dir_d;

  assign retire        = tx_done | abort_done;
  assign pend_set_ok   = pend_w1 & dir_q;
  assign cancel_set_ok = cancel_w1 & pend_q & dir_q;
  assign dir_d         = RX_ONLY ? 1'b0 : (dir_we ? dir_val : dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      pend_q   <= 1'b0;
      cancel_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      dir_q    <= dir_d;
      pend_q   <= retire ? 1'b0 : (pend_q | pend_set_ok);
      cancel_q <= retire ? 1'b0 : (cancel_q | cancel_set_ok);
      ack_q    <= tx_done | (ack_q & ~ack_w1);
    end
  end

  assert_cancel_implies_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |-> pend_q);

  assert_pend_rise_needs_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(dir_q));

  assert_abort_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> (!pend_q && !cancel_q));

  assert_success_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (ack_q && !pend_q && !cancel_q));

  assert_ack_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w1 && !tx_done) |=> !ack_q);

  assert_ack_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w1 && tx_done) |=> ack_q);

  generate
    if (RX_ONLY) begin : g_rx_chk
      assert_rx_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_q && !pend_q && !cancel_q));
    end
  endgenerate
endmodule

// File: rtl/can_txstat_regs.sv
module can_txstat_regs #(
  parameter int NUM_MB = 32,
  parameter int WORD_W = 16,
  localparam int HALVES = NUM_MB / WORD_W,
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int ADDR_W = HALF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NUM_MB-1:0] tx_done,
  input  logic [NUM_MB-1:0] abort_done,
  output logic [NUM_MB-1:0] pend_vec,
  output logic [NUM_MB-1:0] cancel_vec
);
  logic [NUM_MB-1:0] pend_w1, cancel_w1, ack_w1, dir_we, dir_val;
  logic [NUM_MB-1:0] pend_q, cancel_q, ack_q, dir_q;

  can_txstat_wdec #(.NUM_MB(NUM_MB), .WORD_W(WORD_W)) u_wdec (
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .pend_w1   (pend_w1),
    .cancel_w1 (cancel_w1),
    .ack_w1    (ack_w1),
    .dir_we    (dir_we),
    .dir_val   (dir_val)
  );

  generate
    for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
      can_txstat_mbox #(.RX_ONLY(m == 0)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_w1    (pend_w1[m]),
        .cancel_w1  (cancel_w1[m]),
        .ack_w1     (ack_w1[m]),
        .dir_we     (dir_we[m]),
        .dir_val    (dir_val[m]),
        .tx_done    (tx_done[m]),
        .abort_done (abort_done[m]),
        .pend_q     (pend_q[m]),
        .cancel_q   (cancel_q[m]),
        .ack_q      (ack_q[m]),
        .dir_q      (dir_q[m])
      );
    end
  endgenerate

  can_txstat_rmux #(.NUM_MB(NUM_MB), .WORD_W(WORD_W)) u_rmux (
    .addr   (bus_addr),
    .pend   (pend_q),
    .cancel (cancel_q),
    .ack    (ack_q),
    .dir    (dir_q),
    .rdata  (bus_rdata)
  );

  assign pend_vec   = pend_q;
  assign cancel_vec = cancel_q;

  assert_write_ack_unrelated_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && tx_done == '0) |=> (ack_q == $past(ack_q)));
endmodule

// File: tb/test_can_txstat_regs.sv
module test_can_txstat_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] tx_done = '0;
  logic [31:0] abort_done = '0;
  logic [31:0] pend_vec, cancel_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pend = '0, m_can = '0, m_ack = '0, m_dir = '0;

  always #4 clk = ~clk;

  can_txstat_regs i_can_txstat_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_done(tx_done),
    .abort_done(abort_done), .pend_vec(pend_vec), .cancel_vec(cancel_vec)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] model_vec(input logic [1:0] k);
    case (k)
      2'd0: return m_pend;
      2'd1: return m_can;
      2'd2: return m_ack;
      default: return m_dir;
    endcase
  endfunction

  // one clock: bus write and engine pulses together, model advanced alongside
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                     input logic [31:0] txd, input logic [31:0] abd);
    logic [31:0] wm, np, nc, na, nd, retire;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tx_done = txd; abort_done = abd;
    wm = a[0] ? {d, 16'h0000} : {16'h0000, d};
    retire = txd | abd;
    np = m_pend | ((wr && a[2:1] == 2'd0) ? (wm & m_dir) : 32'h0);
    np = np & ~retire;
    nc = m_can | ((wr && a[2:1] == 2'd1) ? (wm & m_pend & m_dir) : 32'h0);
    nc = nc & ~retire;
    na = (m_ack & ~((wr && a[2:1] == 2'd2) ? wm : 32'h0)) | txd;
    nd = m_dir;
    if (wr && a[2:1] == 2'd3) begin
      if (a[0]) nd[31:16] = d; else nd[15:0] = d;
    end
    nd[0] = 1'b0;
    @(posedge clk);
    #1;
    m_pend = np; m_can = nc; m_ack = na; m_dir = nd;
    bus_wr = 1'b0; tx_done = '0; abort_done = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, $sformatf("addr %0d", a), {16'h0, v}, {16'h0, exp});
  endtask

  task automatic compare_all(input string req);
    logic [15:0] v;
    logic [31:0] mv;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      mv = model_vec(2'(a >> 1));
      check(req, $sformatf("model addr %0d", a), {16'h0, v},
            {16'h0, (a % 2 == 1) ? mv[31:16] : mv[15:0]});
    end
    check("R11", "pend_vec", pend_vec, m_pend);
    check("R11", "cancel_vec", cancel_vec, m_can);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    compare_all("R1");
    check("R1", "pend_vec reset", pend_vec, 32'h0);

    // R3: direction, mailbox 0 forced to receive
    cyc(1, 3'd6, 16'hFFFF, 0, 0);
    read_chk("R3", 3'd6, 16'hFFFE);
    cyc(1, 3'd7, 16'h00FF, 0, 0);
    read_chk("R3", 3'd7, 16'h00FF);

    // R4: pending follows direction; write 0 no effect
    cyc(1, 3'd0, 16'hFFFF, 0, 0);
    cyc(1, 3'd1, 16'hFFFF, 0, 0);
    read_chk("R4", 3'd0, 16'hFFFE);
    read_chk("R4", 3'd1, 16'h00FF);
    cyc(1, 3'd0, 16'h0000, 0, 0);
    read_chk("R4", 3'd0, 16'hFFFE);
    check("R11", "pend_vec", pend_vec, 32'h00FF_FFFE);
    compare_all("R2");

    // R7: success on mailbox 1
    cyc(0, 3'd0, 16'h0, 32'h0000_0002, 0);
    read_chk("R7", 3'd0, 16'hFFFC);
    read_chk("R7", 3'd4, 16'h0002);

    // R5: cancel only where pending and transmit
    cyc(1, 3'd2, 16'hFFFF, 0, 0);
    read_chk("R5", 3'd2, 16'hFFFC);
    read_chk("R10", 3'd2, 16'hFFFC & 16'hFFFE);
    cyc(1, 3'd3, 16'hFFFF, 0, 0);
    read_chk("R5", 3'd3, 16'h00FF);
    cyc(1, 3'd2, 16'h0000, 0, 0);
    read_chk("R5", 3'd2, 16'hFFFC);

    // R6: abort on mailboxes 2,3 with a same-cycle pending write
    cyc(1, 3'd0, 16'h000C, 0, 32'h0000_000C);
    read_chk("R6", 3'd2, 16'hFFF0);
    read_chk("R6", 3'd0, 16'hFFF0);
    read_chk("R6", 3'd4, 16'h0002);

    // R7: success on 4 and 16
    cyc(0, 3'd0, 16'h0, 32'h0001_0010, 0);
    read_chk("R7", 3'd4, 16'h0012);
    read_chk("R7", 3'd5, 16'h0001);
    read_chk("R7", 3'd2, 16'hFFE0);
    read_chk("R7", 3'd3, 16'h00FE);

    // R8 / R9
    cyc(1, 3'd4, 16'h0000, 0, 0);
    read_chk("R8", 3'd4, 16'h0012);
    cyc(1, 3'd4, 16'h0012, 32'h0000_0010, 0);
    read_chk("R9", 3'd4, 16'h0010);
    cyc(1, 3'd5, 16'hFFFF, 0, 0);
    read_chk("R8", 3'd5, 16'h0000);
    compare_all("R8");

    // sweep: pseudo-random mix against the model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0] | lfsr[8], lfsr[3:1], lfsr[19:4],
          lfsr[20] ? (32'h1 << lfsr[25:21]) : 32'h0,
          (lfsr[26] & lfsr[9]) ? (32'h1 << lfsr[31:27]) : 32'h0);
      compare_all("R11");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule